// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received Ethernet frames into a circular byte buffer in memory. A MAC in front of it delivers each frame as a byte stream, one byte per valid cycle. On the last byte it also gives the CRC verdict, an alignment-error flag and the address class of the frame: broadcast, multicast or unicast match to the station. For each frame that passes the acceptance rules and fits in the free space, the block writes the frame bytes after a 4-byte slot. Once the frame has ended it fills that slot with a little-endian header: a 16-bit status word, then the 16-bit byte count, which includes the CRC. It then moves its write pointer to the next 32-bit boundary.

The host drains the ring by reading packets from its read position. It moves that position through a register that is biased by 0x10 below the true offset. A flag reports whether unread packets remain. Two sticky interrupt bits signal a stored good frame or a stored frame with errors. A counter records frames lost for lack of space. The ring size is 8 KB shifted left by a 2-bit code. Clearing the receive enable abandons any frame in progress and returns both pointers to offset zero. Frames must be separated by at least one idle input cycle, because the header is written in the cycle after the last byte.

Top module: `rx_ring_writer`

## Requirements
- R1: A stored frame starting at offset S puts the status word in bytes S and S+1 (low byte first), the byte count in bytes S+2 and S+3 (low byte first), and frame byte i at S+4+i, all modulo the ring size. Data bytes are written with a single byte enable; the header is written as a full 32-bit word.
- R2: In the status word, bit 0 is good (set only when no other status bit is set), bit 1 is the alignment-error flag, bit 2 is set when the CRC is bad, bit 3 is set when the count exceeds 4096, and bit 4 is set when the count is below 64. Bits 15..5 are zero.
- R3: The next frame starts at S plus the count plus 4, rounded up to a multiple of 4. Every memory write address is a multiple of 4.
- R4: The ring size is 8192 shifted left by size_code (0..3 gives 8, 16, 32 or 64 KB), and every position wraps modulo that size.
- R5: host_rp reads the read offset minus 0x10 (16 bits). A write of value V sets the read offset to (V + 0x10) modulo the ring size, with bits 1..0 cleared. After reset the register reads 0xFFF0.
- R6: buf_empty is 1 exactly when the read offset equals the write offset.
- R7: A frame is stored only if its class matches an enabled class (broadcast with acc_bcast, multicast with acc_mcast, station match with acc_phys). A count below 64 also requires acc_runt. A bad CRC, alignment error or count above 4096 also requires acc_err. A rejected frame leaves the write pointer, the header area it would use and the interrupt bits unchanged.
- R8: With free space F equal to the ring size when empty, and otherwise to (read - write) modulo the size, a frame is stored only if count + 8 <= F. Otherwise it is dropped, missed_cnt increases by one and the write pointer is unchanged.
- R9: irq_rok sets when a stored frame has status bit 0 set. irq_rer sets when a stored frame has bit 0 clear. Both bits are sticky and are cleared by writing 1 to irq_clr bit 0 or bit 1 respectively. A set in the same cycle takes priority over a clear.
- R10: While rx_en is 0, no memory writes occur, a frame in progress is discarded and both pointers return to 0, so the ring is empty and host_rp reads 0xFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; low resets the receive path |
| size_code | input | 2 | Ring size select, 8 KB << code |
| acc_bcast | input | 1 | Accept broadcast frames |
| acc_mcast | input | 1 | Accept multicast frames |
| acc_phys | input | 1 | Accept station-address frames |
| acc_runt | input | 1 | Accept frames under 64 bytes |
| acc_err | input | 1 | Accept frames with CRC, alignment or length errors |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_crc_ok | input | 1 | CRC good, valid with rx_last |
| rx_align_err | input | 1 | Alignment error, valid with rx_last |
| rx_is_bcast | input | 1 | Broadcast class, valid with rx_last |
| rx_is_mcast | input | 1 | Multicast class, valid with rx_last |
| rx_is_phys | input | 1 | Station-match class, valid with rx_last |
| host_rp_we | input | 1 | Write strobe for the host read register |
| host_rp_wdata | input | 16 | Host read register write value |
| host_rp | output | 16 | Host read register (read offset - 0x10) |
| buf_empty | output | 1 | No unread packet in the ring |
| irq_clr | input | 2 | Write-1-to-clear: bit 0 good, bit 1 error |
| irq_rok | output | 1 | Good frame stored |
| irq_rer | output | 1 | Errored frame stored |
| missed_cnt | output | 8 | Frames dropped for lack of space |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |

## Verification
The bench targets the rounding of the next start for odd counts. A design that skipped the round-up or left out the header slot would put the following header at the wrong offset. It fills an 8 KB ring until the free space is exactly four bytes short, then exactly enough. An off-by-one in the space test would either overwrite unread data or drop a frame that fits. A frame is made to straddle the end of the ring so that its bytes must wrap to offset zero. The bench also checks that rejected and aborted frames leave no header and no interrupt, and that a 16 KB code places a header at 8192 where an 8 KB ring would wrap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int unsigned ST_OK    = 0;
    localparam int unsigned ST_ALIGN = 1;
    localparam int unsigned ST_CRC   = 2;
    localparam int unsigned ST_LONG  = 3;
    localparam int unsigned ST_RUNT  = 4;

    localparam int unsigned RUNT_LIMIT = 64;
    localparam int unsigned LONG_LIMIT = 4096;
    localparam int unsigned HOST_BIAS  = 16;
    localparam int unsigned HDR_BYTES  = 4;

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic phys;
        logic runt;
        logic err;
    } accept_cfg_t;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int AW        = 16,
    parameter int BASE_LOG2 = 13,
    parameter int CODE_W    = 2
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic [AW-1:0]     rd,
    input  logic [AW-1:0]     wr,
    input  logic [AW:0]       cnt,
    output logic [AW-1:0]     mask,
    output logic              fit
);
    logic [AW:0]   size_full;
    logic [AW-1:0] diff;
    logic [AW:0]   free_bytes;

    always_comb begin
        size_full  = (AW+1)'(1) << (BASE_LOG2 + int'(size_code));
        mask       = AW'(size_full - (AW+1)'(1));
        diff       = (rd - wr) & mask;
        free_bytes = (diff == '0) ? size_full : {1'b0, diff};
        // byte index cnt fits if header + bytes so far + one more + guard word stay inside
        fit        = (cnt + (AW+1)'(2 * rxr_pkg::HDR_BYTES + 1)) <= free_bytes;
    end
endmodule

// File: rtl/rxr_classify.sv
module rxr_classify #(
    parameter int LW = 17
) (
    input  logic [LW-1:0]             len,
    input  logic                      crc_ok,
    input  logic                      align_err,
    input  logic                      is_bcast,
    input  logic                      is_mcast,
    input  logic                      is_phys,
    input  rxr_pkg::accept_cfg_t      cfg,
    output logic [15:0]               status,
    output logic                      keep,
    output logic                      good
);
    import rxr_pkg::*;

    logic runt, too_long, err, addr_hit;

    always_comb begin
        runt     = len < LW'(RUNT_LIMIT);
        too_long = len > LW'(LONG_LIMIT);
        err      = !crc_ok || align_err || too_long;
        good     = !err && !runt;
        status            = '0;
        status[ST_OK]     = good;
        status[ST_ALIGN]  = align_err;
        status[ST_CRC]    = !crc_ok;
        status[ST_LONG]   = too_long;
        status[ST_RUNT]   = runt;
        addr_hit = (is_bcast && cfg.bcast) || (is_mcast && cfg.mcast) || (is_phys && cfg.phys);
        keep     = addr_hit && (!runt || cfg.runt) && (!err || cfg.err);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int BASE_LOG2 = 13,
    parameter int CODE_W    = 2,
    parameter int MISS_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rx_en,
    input  logic [CODE_W-1:0]                     size_code,
    input  logic                                  acc_bcast,
    input  logic                                  acc_mcast,
    input  logic                                  acc_phys,
    input  logic                                  acc_runt,
    input  logic                                  acc_err,
    input  logic                                  rx_valid,
    input  logic [7:0]                            rx_data,
    input  logic                                  rx_last,
    input  logic                                  rx_crc_ok,
    input  logic                                  rx_align_err,
    input  logic                                  rx_is_bcast,
    input  logic                                  rx_is_mcast,
    input  logic                                  rx_is_phys,
    input  logic                                  host_rp_we,
    input  logic [BASE_LOG2+(1<<CODE_W)-2:0]      host_rp_wdata,
    output logic [BASE_LOG2+(1<<CODE_W)-2:0]      host_rp,
    output logic                                  buf_empty,
    input  logic [1:0]                            irq_clr,
    output logic                                  irq_rok,
    output logic                                  irq_rer,
    output logic [MISS_W-1:0]                     missed_cnt,
    output logic                                  mem_we,
    output logic [BASE_LOG2+(1<<CODE_W)-2:0]      mem_addr,
    output logic [3:0]                            mem_be,
    output logic [31:0]                           mem_wdata
);
    import rxr_pkg::*;

    localparam int AW = BASE_LOG2 + (1 << CODE_W) - 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              drop;
        logic              pend;
        logic              pend_keep;
        logic              pend_drop;
        logic              pend_good;
        logic [15:0]       pend_status;
        logic [15:0]       pend_len;
        logic [AW-1:0]     wr;
        logic [AW-1:0]     rd;
        logic              irq_rok;
        logic              irq_rer;
        logic [MISS_W-1:0] missed;
        logic              mem_we;
        logic [AW-1:0]     mem_addr;
        logic [3:0]        mem_be;
        logic [31:0]       mem_wdata;
    } state_t;

    state_t q, d;

    logic [AW-1:0] mask;
    logic          fit;
    logic [15:0]   cls_status;
    logic          cls_keep;
    logic          cls_good;
    logic [CW-1:0] len_now;
    accept_cfg_t   cfg;

    assign len_now = q.cnt + CW'(1);
    assign cfg     = '{bcast: acc_bcast, mcast: acc_mcast, phys: acc_phys,
                       runt: acc_runt, err: acc_err};

    rxr_space #(.AW(AW), .BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_space (
        .size_code (size_code),
        .rd        (q.rd),
        .wr        (q.wr),
        .cnt       (q.cnt),
        .mask      (mask),
        .fit       (fit)
    );

    rxr_classify #(.LW(CW)) u_class (
        .len       (len_now),
        .crc_ok    (rx_crc_ok),
        .align_err (rx_align_err),
        .is_bcast  (rx_is_bcast),
        .is_mcast  (rx_is_mcast),
        .is_phys   (rx_is_phys),
        .cfg       (cfg),
        .status    (cls_status),
        .keep      (cls_keep),
        .good      (cls_good)
    );

    logic [AW-1:0] step;
    logic [AW-1:0] baddr;

    always_comb begin
        d           = q;
        d.mem_we    = 1'b0;
        d.mem_be    = '0;
        d.irq_rok   = q.irq_rok && !irq_clr[0];
        d.irq_rer   = q.irq_rer && !irq_clr[1];
        step        = (AW'(q.pend_len) + AW'(HDR_BYTES + 3)) & ~AW'(3);
        baddr       = (q.wr + AW'(HDR_BYTES) + q.cnt[AW-1:0]) & mask;

        // commit of the frame that ended last cycle: header word and pointer move
        if (q.pend) begin
            d.pend = 1'b0;
            if (q.pend_drop) begin
                d.missed = q.missed + MISS_W'(1);
            end else if (q.pend_keep) begin
                d.mem_we    = 1'b1;
                d.mem_addr  = q.wr;
                d.mem_be    = 4'hF;
                d.mem_wdata = {q.pend_len, q.pend_status};
                d.wr        = (q.wr + step) & mask;
                if (q.pend_good) d.irq_rok = 1'b1;
                else             d.irq_rer = 1'b1;
            end
        end

        if (host_rp_we) begin
            d.rd = (host_rp_wdata + AW'(HOST_BIAS)) & mask & ~AW'(3);
        end

        if (rx_valid) begin
            d.cnt = q.cnt + CW'(1);
            if (!q.drop && fit) begin
                d.mem_we    = 1'b1;
                d.mem_addr  = baddr & ~AW'(3);
                d.mem_be    = 4'b0001 << baddr[1:0];
                d.mem_wdata = {4{rx_data}};
            end else begin
                d.drop = 1'b1;
            end
            if (rx_last) begin
                d.pend        = 1'b1;
                d.pend_drop   = q.drop || !fit;
                d.pend_keep   = cls_keep;
                d.pend_good   = cls_good;
                d.pend_status = cls_status;
                d.pend_len    = 16'(len_now);
                d.cnt         = '0;
                d.drop        = 1'b0;
            end
        end

        if (!rx_en) begin
            d.cnt    = '0;
            d.drop   = 1'b0;
            d.pend   = 1'b0;
            d.wr     = '0;
            d.rd     = '0;
            d.mem_we = 1'b0;
            d.mem_be = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rp    = q.rd - AW'(HOST_BIAS);
    assign buf_empty  = (q.rd == q.wr);
    assign irq_rok    = q.irq_rok;
    assign irq_rer    = q.irq_rer;
    assign missed_cnt = q.missed;
    assign mem_we     = q.mem_we;
    assign mem_addr   = q.mem_addr;
    assign mem_be     = q.mem_be;
    assign mem_wdata  = q.mem_wdata;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int BASE_LOG2 = 13,
    parameter int CODE_W    = 2,
    parameter int MISS_W    = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               rx_en,
    input logic                               buf_empty,
    input logic                               irq_rok,
    input logic [MISS_W-1:0]                  missed_cnt,
    input logic                               mem_we,
    input logic [BASE_LOG2+(1<<CODE_W)-2:0]   mem_addr,
    input logic [3:0]                         mem_be
);
    localparam int AW = BASE_LOG2 + (1 << CODE_W) - 1;

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == (mem_addr & ~AW'(3))));  // R3
    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($onehot(mem_be) || mem_be == 4'hF));  // R1
    AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !mem_we);  // R10
    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> buf_empty);  // R10
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt == $past(missed_cnt)) || (missed_cnt == $past(missed_cnt) + 1'b1));  // R8
    AST_ROK_WITH_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rok) |-> (mem_we && mem_be == 4'hF));  // R9
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
    .BASE_LOG2 (BASE_LOG2),
    .CODE_W    (CODE_W),
    .MISS_W    (MISS_W)
) u_chk (.*);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [1:0]  size_code = 2'd0;
    logic        acc_bcast = 1'b1, acc_mcast = 1'b1, acc_phys = 1'b1;
    logic        acc_runt = 1'b1, acc_err = 1'b1;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_crc_ok = 1'b1, rx_align_err = 1'b0;
    logic        rx_is_bcast = 1'b0, rx_is_mcast = 1'b0, rx_is_phys = 1'b0;
    logic        host_rp_we = 1'b0;
    logic [15:0] host_rp_wdata = '0;
    logic [15:0] host_rp;
    logic        buf_empty;
    logic [1:0]  irq_clr = '0;
    logic        irq_rok, irq_rer;
    logic [7:0]  missed_cnt;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int exp_wr = 0;
    logic [7:0] mem [int];

    always #5 clk = ~clk;

    rx_ring_writer u_dut (.*);

    always @(posedge clk) begin
        if (mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[int'(mem_addr) + l] = mem_wdata[8*l +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i * 3);
    endfunction

    function automatic int next_start(input int s, input int len, input int size);
        return (s + ((len + 4 + 3) / 4) * 4) % size;
    endfunction

    function automatic logic [7:0] rd_mem(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'hxx;
    endfunction

    task automatic expect_hdr(input string tag, input int s, input int st, input int len);
        chk({tag, " status"}, {16'h0, rd_mem(s + 1), rd_mem(s)}, 32'(st));
        chk({tag, " length"}, {16'h0, rd_mem(s + 3), rd_mem(s + 2)}, 32'(len));
    endtask

    task automatic send(input int len, input logic [7:0] seed, input logic crc, input logic aln,
                        input logic bc, input logic mc, input logic ph);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == len - 1);
            rx_crc_ok = crc; rx_align_err = aln;
            rx_is_bcast = bc; rx_is_mcast = mc; rx_is_phys = ph;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_set_rd(input int off);
        @(negedge clk);
        host_rp_we = 1'b1; host_rp_wdata = 16'(off - 16);
        @(negedge clk);
        host_rp_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 2'b11;
        @(negedge clk); irq_clr = 2'b00;
        @(negedge clk);
    endtask

    task automatic reenable();
        @(negedge clk); rx_en = 1'b0;
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        exp_wr = 0;
    endtask

    task automatic t_reset();
        chk("R6 empty after reset", buf_empty, 1);
        chk("R5 host_rp after reset", host_rp, 16'hFFF0);
        chk("R9 irq_rok after reset", irq_rok, 0);
        chk("R9 irq_rer after reset", irq_rer, 0);
        chk("R8 missed after reset", missed_cnt, 0);
    endtask

    task automatic t_basic();
        send(64, 8'h10, 1, 0, 1, 0, 0);
        expect_hdr("R1 R2 good frame", exp_wr, 16'h0001, 64);
        chk("R1 first data byte", rd_mem(exp_wr + 4), pat(8'h10, 0));
        chk("R1 last data byte", rd_mem(exp_wr + 4 + 63), pat(8'h10, 63));
        chk("R6 not empty after store", buf_empty, 0);
        chk("R9 irq_rok after good", irq_rok, 1);
        exp_wr = next_start(exp_wr, 64, 8192);
        host_set_rd(exp_wr);
        chk("R6 empty after host catch-up", buf_empty, 1);
        chk("R5 host_rp readback", host_rp, 16'(exp_wr - 16));
    endtask

    task automatic t_align();
        send(65, 8'h20, 1, 0, 0, 0, 1);
        expect_hdr("R3 odd frame", exp_wr, 16'h0001, 65);
        exp_wr = next_start(exp_wr, 65, 8192);
        chk("R3 rounded start", exp_wr, 140);
        send(100, 8'h30, 1, 0, 1, 0, 0);
        expect_hdr("R3 frame after odd", exp_wr, 16'h0001, 100);
        exp_wr = next_start(exp_wr, 100, 8192);
        host_set_rd(exp_wr);
    endtask

    task automatic t_errors();
        clear_irq();
        chk("R9 irq_rok cleared", irq_rok, 0);
        send(80, 8'h40, 0, 0, 1, 0, 0);
        expect_hdr("R2 crc error", exp_wr, 16'h0004, 80);
        chk("R9 irq_rer on error", irq_rer, 1);
        chk("R9 irq_rok stays clear", irq_rok, 0);
        exp_wr = next_start(exp_wr, 80, 8192);
        send(80, 8'h41, 1, 1, 1, 0, 0);
        expect_hdr("R2 align error", exp_wr, 16'h0002, 80);
        exp_wr = next_start(exp_wr, 80, 8192);
        clear_irq();
        acc_err = 1'b0;
        send(80, 8'h42, 0, 0, 1, 0, 0);
        chk("R7 rejected error: irq_rer", irq_rer, 0);
        chk("R7 rejected error: irq_rok", irq_rok, 0);
        send(64, 8'h43, 1, 0, 1, 0, 0);
        expect_hdr("R7 next frame at unchanged start", exp_wr, 16'h0001, 64);
        exp_wr = next_start(exp_wr, 64, 8192);
        acc_err = 1'b1;
        host_set_rd(exp_wr);
    endtask

    task automatic t_runt_filter();
        send(40, 8'h50, 1, 0, 1, 0, 0);
        expect_hdr("R2 runt", exp_wr, 16'h0010, 40);
        exp_wr = next_start(exp_wr, 40, 8192);
        acc_runt = 1'b0;
        send(40, 8'h51, 1, 0, 1, 0, 0);
        acc_mcast = 1'b0;
        send(64, 8'h52, 1, 0, 0, 1, 0);
        send(64, 8'h53, 1, 0, 0, 0, 1);
        expect_hdr("R7 runt and multicast rejected", exp_wr, 16'h0001, 64);
        exp_wr = next_start(exp_wr, 64, 8192);
        acc_mcast = 1'b1; acc_runt = 1'b1;
        send(64, 8'h54, 1, 0, 0, 1, 0);
        expect_hdr("R7 multicast accepted", exp_wr, 16'h0001, 64);
        exp_wr = next_start(exp_wr, 64, 8192);
        host_set_rd(exp_wr);
    endtask

    task automatic t_reenable();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b0;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 empty while disabled", buf_empty, 1);
        chk("R10 host_rp while disabled", host_rp, 16'hFFF0);
        rx_en = 1'b1;
        @(negedge clk);
        exp_wr = 0;
        send(64, 8'h60, 1, 0, 1, 0, 0);
        expect_hdr("R10 frame after re-enable at zero", 0, 16'h0001, 64);
    endtask

    task automatic t_space();
        reenable();
        for (int k = 0; k < 7; k++) begin
            send(1020, 8'(k), 1, 0, 1, 0, 0);
            exp_wr = next_start(exp_wr, 1020, 8192);
        end
        expect_hdr("R8 seventh frame", 6144, 16'h0001, 1020);
        send(1020, 8'h70, 1, 0, 1, 0, 0);
        chk("R8 missed after overflow", missed_cnt, 1);
        send(1016, 8'h71, 1, 0, 1, 0, 0);
        expect_hdr("R8 exact fit stored at unchanged start", exp_wr, 16'h0001, 1016);
        chk("R8 missed unchanged on exact fit", missed_cnt, 1);
        exp_wr = next_start(exp_wr, 1016, 8192);
        chk("R8 exact fit write pointer", exp_wr, 8188);
    endtask

    task automatic t_wrap();
        host_set_rd(8188);
        send(1100, 8'h55, 1, 0, 1, 0, 0);
        expect_hdr("R4 header before wrap", 8188, 16'h0001, 1100);
        chk("R4 byte 0 wrapped", rd_mem(0), pat(8'h55, 0));
        chk("R4 byte 20 wrapped", rd_mem(20), pat(8'h55, 20));
        chk("R6 not empty after wrap", buf_empty, 0);
        exp_wr = next_start(8188, 1100, 8192);
        host_set_rd(exp_wr);
        chk("R3 wrapped next start", buf_empty, 1);
    endtask

    task automatic t_size();
        size_code = 2'd1;
        reenable();
        for (int k = 0; k < 8; k++) begin
            send(1020, 8'(k + 8'h80), 1, 0, 1, 0, 0);
            exp_wr = next_start(exp_wr, 1020, 16384);
        end
        send(64, 8'h90, 1, 0, 1, 0, 0);
        expect_hdr("R4 16K ring no wrap at 8192", 8192, 16'h0001, 64);
        exp_wr = next_start(8192, 64, 16384);
        host_set_rd(exp_wr);
        clear_irq();
        send(4100, 8'h91, 1, 0, 1, 0, 0);
        expect_hdr("R2 long frame", exp_wr, 16'h0008, 4100);
        chk("R9 irq_rer on long", irq_rer, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        @(negedge clk);
        t_basic();
        t_align();
        t_errors();
        t_runt_filter();
        t_reenable();
        t_space();
        t_wrap();
        t_size();
        finish_run();
    end
endmodule